// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running BCD calendar and raises a sticky alarm interrupt when the time reaches a programmed value. Software programs six alarm values (second, minute, hour, day of month, month, three-digit year) and a control word. The control word enables each field on its own and carries a global enable. The calendar itself is kept elsewhere. It delivers its six current BCD fields and a one-cycle strobe once per second, in the cycle after it has advanced.

In each strobe cycle the enabled alarm fields are compared with the calendar. If any one enabled field is equal, the alarm fires. This is an OR across the fields, not a full date-time match. The pending flag then stays set, and drives the interrupt, until software writes a one to clear it. Alarm values are cut to their BCD widths when written, and read back in that form.

Top module: `masked_alarm_cmp`

## Requirements
- R1: After reset the control word, all six alarm values and the pending flag read as zero, and `alarm_irq_o` is low.
- R2: Writes store only the BCD width of each alarm field: seconds 7 bits (address 1), minutes 7 bits (2), hours 6 bits (3), day 6 bits (4), month 5 bits (5), year 12 bits (6). The control word at address 0 keeps bits [6:0]. Upper bits read as zero.
- R3: Control bits 0..5 enable the comparison of seconds, minutes, hours, day, month and year respectively. A disabled field never fires the alarm, even if its value is equal. The month is compared as the 1-based BCD value on `cal_mon_i`.
- R4: An equal value in any single enabled field fires the alarm, even when all other enabled fields differ.
- R5: When control bit 6 (global enable) is zero, no comparison fires the alarm.
- R6: Comparison happens only in a cycle with `sec_strobe_i` high. The pending flag and `alarm_irq_o` rise at the next clock edge.
- R7: The year compares all 12 bits as three BCD digits: hundreds in [11:8], tens and units in [7:0].
- R8: The pending flag reads at bit 1 of address 7 and equals `alarm_irq_o`. It stays set until a write to address 7 with bit 1 high. A write there with bit 1 low has no effect.
- R9: If an alarm fires in the same cycle as a clearing write, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_strobe_i | input | 1 | One-cycle pulse per second, calendar already advanced |
| cal_sec_i | input | 8 | Current seconds, BCD |
| cal_min_i | input | 8 | Current minutes, BCD |
| cal_hour_i | input | 8 | Current hours, BCD |
| cal_day_i | input | 8 | Current day of month, BCD |
| cal_mon_i | input | 8 | Current month, BCD, 1-based |
| cal_year_i | input | 12 | Current year, three BCD digits |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | DATA_W | Read data for rd_addr_i, combinational |
| alarm_irq_o | output | 1 | Sticky alarm interrupt |

## Verification
The two functions that can fall in the same cycle are an alarm match on the second strobe and the write-one-to-clear of the pending flag. The bench provokes this with a matching strobe and a clearing write to address 7 in one cycle, both with the flag clear and with it already set. In both cases it expects the flag to be set after the edge. A behavioural reference model runs beside the design. It computes the match from the register values held before that cycle's writes, and is compared on every clock.

// File: rtl/alm_cmp_pkg.sv
package alm_cmp_pkg;
  localparam int NFIELD     = 6;
  localparam int VAL_W      = 12;
  localparam int CTRL_W     = 7;
  localparam int GEN_EN_BIT = 6;
  localparam int PEND_BIT   = 1;
  localparam int ADDR_W     = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_SEC  = 3'd1,
    A_MIN  = 3'd2,
    A_HOUR = 3'd3,
    A_DAY  = 3'd4,
    A_MON  = 3'd5,
    A_YEAR = 3'd6,
    A_STAT = 3'd7
  } reg_addr_e;

  typedef logic [NFIELD-1:0][VAL_W-1:0] fld_vec_t;

  function automatic int fld_width(input int idx);
    case (idx)
      0, 1:    return 7;
      2, 3:    return 6;
      4:       return 5;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/alm_regs.sv
module alm_regs
  import alm_cmp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [CTRL_W-1:0]   ctrl_o,
  output fld_vec_t            alm_val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  ctrl_o <= '0;
    else if (wr_en_i && wr_addr_i == A_CTRL)      ctrl_o <= wr_data_i[CTRL_W-1:0];
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    localparam int              FW   = fld_width(i);
    localparam logic [VAL_W-1:0] MASK = VAL_W'((1 << FW) - 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        alm_val_o[i] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(i + 1))
        alm_val_o[i] <= wr_data_i[VAL_W-1:0] & MASK;
    end
  end
endmodule

// File: rtl/alm_match.sv
module alm_match
  import alm_cmp_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  input  fld_vec_t          alm_val_i,
  input  fld_vec_t          cur_val_i,
  output logic              hit_o
);
  logic [NFIELD-1:0] fld_hit;

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    assign fld_hit[i] = ctrl_i[i] && (alm_val_i[i] == cur_val_i[i]);
  end

  assign hit_o = ctrl_i[GEN_EN_BIT] && (|fld_hit);
endmodule

// File: rtl/alm_pending.sv
module alm_pending (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  // set has priority so a same-cycle event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/masked_alarm_cmp.sv
module masked_alarm_cmp
  import alm_cmp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_strobe_i,
  input  logic [7:0]        cal_sec_i,
  input  logic [7:0]        cal_min_i,
  input  logic [7:0]        cal_hour_i,
  input  logic [7:0]        cal_day_i,
  input  logic [7:0]        cal_mon_i,
  input  logic [11:0]       cal_year_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              alarm_irq_o
);
  logic [CTRL_W-1:0] ctrl_q;
  fld_vec_t          alm_val;
  fld_vec_t          cur_val;
  logic              any_hit;
  logic              pend_clr;

  assign cur_val[0] = VAL_W'(cal_sec_i);
  assign cur_val[1] = VAL_W'(cal_min_i);
  assign cur_val[2] = VAL_W'(cal_hour_i);
  assign cur_val[3] = VAL_W'(cal_day_i);
  assign cur_val[4] = VAL_W'(cal_mon_i);
  assign cur_val[5] = cal_year_i;

  alm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl_q),
    .alm_val_o (alm_val)
  );

  alm_match u_match (
    .ctrl_i    (ctrl_q),
    .alm_val_i (alm_val),
    .cur_val_i (cur_val),
    .hit_o     (any_hit)
  );

  assign pend_clr = wr_en_i && (wr_addr_i == A_STAT) && wr_data_i[PEND_BIT];

  alm_pending u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sec_strobe_i && any_hit),
    .clr_i  (pend_clr),
    .pend_o (alarm_irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_CTRL) rd_data_o = DATA_W'(ctrl_q);
    if (rd_addr_i == A_STAT) rd_data_o[PEND_BIT] = alarm_irq_o;
    for (int i = 0; i < NFIELD; i++)
      if (rd_addr_i == ADDR_W'(i + 1)) rd_data_o = DATA_W'(alm_val[i]);
  end
endmodule

// File: rtl/alm_cmp_chk.sv
module alm_cmp_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sec_strobe_i,
  input logic              wr_en_i,
  input logic [2:0]        wr_addr_i,
  input logic              wr_clr_bit_i,
  input logic [2:0]        rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              alarm_irq_o,
  input logic              gen_en_i,
  input logic              hit_i
);
  logic clr_wr;
  assign clr_wr = wr_en_i && wr_addr_i == 3'd7 && wr_clr_bit_i;

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_irq_o && !clr_wr |=> alarm_irq_o);

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && !(sec_strobe_i && hit_i) |=> !alarm_irq_o);

  a_r6_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alarm_irq_o && !sec_strobe_i |=> !alarm_irq_o);

  a_r5_global_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alarm_irq_o && !gen_en_i |=> !alarm_irq_o);

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_strobe_i && hit_i |=> alarm_irq_o);

  a_r2_sec_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_i == 3'd1 |-> rd_data_o[DATA_W-1:7] == '0);
endmodule

bind masked_alarm_cmp alm_cmp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sec_strobe_i (sec_strobe_i),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_clr_bit_i (wr_data_i[1]),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .alarm_irq_o  (alarm_irq_o),
  .gen_en_i     (ctrl_q[6]),
  .hit_i        (any_hit)
);

// File: tb/tb_masked_alarm_cmp.sv
module tb_masked_alarm_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stb = 1'b0;
  logic [7:0]  c_sec = 0, c_min = 0, c_hour = 0, c_day = 0, c_mon = 0;
  logic [11:0] c_year = 0;
  logic        we = 1'b0;
  logic [2:0]  wa = 0, ra = 0;
  logic [15:0] wd = 0;
  logic [15:0] rd;
  logic        irq;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  int m_ctrl, m_pend;
  int m_alm[6];
  int mw[6] = '{7, 7, 6, 6, 5, 12};

  always #10 clk = ~clk;

  masked_alarm_cmp dut (
    .clk_i(clk), .rst_ni(rst_n), .sec_strobe_i(stb),
    .cal_sec_i(c_sec), .cal_min_i(c_min), .cal_hour_i(c_hour),
    .cal_day_i(c_day), .cal_mon_i(c_mon), .cal_year_i(c_year),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_addr_i(ra), .rd_data_o(rd), .alarm_irq_o(irq)
  );

  function automatic int model_read(input int a);
    if (a == 0) return m_ctrl;
    if (a == 7) return m_pend << 1;
    return m_alm[a-1];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive, compare against model state, advance model
  task automatic cyc(input bit w, input int a, input int d, input bit s, input int r);
    int cur[6];
    bit hit;
    @(negedge clk);
    we = w; wa = 3'(a); wd = 16'(d); stb = s; ra = 3'(r);
    #1;
    check({cur_req, " read"}, int'(rd), model_read(r));
    check({cur_req, " irq"}, int'(irq), m_pend);
    cur = '{int'(c_sec), int'(c_min), int'(c_hour), int'(c_day), int'(c_mon), int'(c_year)};
    hit = 0;
    for (int i = 0; i < 6; i++)
      if (m_ctrl[i] && m_alm[i] == cur[i]) hit = 1;
    hit = hit && m_ctrl[6] && s;
    if (w) begin
      if (a == 0) m_ctrl = d & 'h7f;
      else if (a == 7) begin if (d[1]) m_pend = 0; end
      else m_alm[a-1] = d & ((1 << mw[a-1]) - 1);
    end
    if (hit) m_pend = 1;
  endtask

  task automatic idle(input int r); cyc(0, 0, 0, 0, r); endtask
  task automatic wr(input int a, input int d); cyc(1, a, d, 0, 7); endtask

  task automatic expect_irq(input string req, input bit e);
    idle(7);
    check(req, int'(irq), int'(e));
  endtask

  task automatic clear_pend();
    wr(7, 2);
    expect_irq("R8 cleared", 0);
  endtask

  initial begin
    m_ctrl = 0; m_pend = 0;
    for (int i = 0; i < 6; i++) m_alm[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cur_req = "R1";
    for (int a = 0; a < 8; a++) begin
      idle(a);
      check("R1 reset read", int'(rd), 0);
    end
    check("R1 irq low", int'(irq), 0);

    // R2 masking on write
    cur_req = "R2";
    for (int a = 0; a < 7; a++) wr(a, 'hffff);
    idle(0); check("R2 ctrl width", int'(rd), 'h7f);
    idle(1); check("R2 sec width", int'(rd), 'h7f);
    idle(3); check("R2 hour width", int'(rd), 'h3f);
    idle(5); check("R2 month width", int'(rd), 'h1f);
    idle(6); check("R2 year width", int'(rd), 'hfff);
    wr(0, 0);

    c_sec = 8'h30; c_min = 8'h15; c_hour = 8'h08; c_day = 8'h21;
    c_mon = 8'h12; c_year = 12'h024;
    wr(1, 'h30); wr(2, 'h45); wr(3, 'h09); wr(4, 'h22); wr(5, 'h12); wr(6, 'h124);

    // R5 global enable off
    cur_req = "R5";
    wr(0, 'h3f);
    cyc(0, 0, 0, 1, 7);
    expect_irq("R5 global off", 0);

    // R6 no strobe, no compare
    cur_req = "R6";
    wr(0, 'h41);
    idle(7); idle(7);
    expect_irq("R6 no strobe", 0);
    cyc(0, 0, 0, 1, 7);
    expect_irq("R6 strobe fires", 1);

    // R8 sticky, write 0 ignored
    cur_req = "R8";
    idle(7); idle(7);
    expect_irq("R8 sticky", 1);
    wr(7, 'hfffd);
    expect_irq("R8 zero bit ignored", 1);
    idle(7); check("R8 status bit", int'(rd), 2);
    clear_pend();

    // R3 per-field enable
    cur_req = "R3";
    foreach (mw[i]) begin
      if (i == 0 || i == 4) continue;
      wr(0, 'h40 | (1 << i));
      cyc(0, 0, 0, 1, 7);
      expect_irq("R3 mismatching field", 0);
    end
    wr(0, 'h10);
    cyc(0, 0, 0, 1, 7);
    expect_irq("R3 gated even on match", 0);

    // R4 any single enabled field
    cur_req = "R4";
    wr(0, 'h7e);
    cyc(0, 0, 0, 1, 7);
    expect_irq("R4 month alone matches", 1);
    clear_pend();

    // R7 three-digit year
    cur_req = "R7";
    wr(0, 'h60);
    c_year = 12'h125;
    cyc(0, 0, 0, 1, 7);
    expect_irq("R7 units differ", 0);
    c_year = 12'h124;
    cyc(0, 0, 0, 1, 7);
    expect_irq("R7 full year match", 1);
    clear_pend();

    // R9 set and clear together
    cur_req = "R9";
    cyc(1, 7, 2, 1, 7);
    expect_irq("R9 set wins from clear", 1);
    cyc(1, 7, 2, 1, 7);
    expect_irq("R9 set wins while pending", 1);
    clear_pend();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule